// File: doc/BRIEF.md
# Two-Pin GPIO Port with Timer Channel Override

This block is a small bidirectional port of two pins, reached over a simple 8-bit memory-mapped register bus. Software programs an output latch and a per-pin direction register, each at its own bus address. A direction bit of 1 turns on that pin's pad driver, and the pad then shows the latch value. A direction bit of 0 leaves the pin as an input. The block presents the level on the pin to software through a two-flop synchronizer.

A timer channel can take over each pin. While a channel's mode-select field is non-zero, the timer's output enable and output value drive the pad, and the direction bit has no say in pad direction. The direction bit still decides what a read of the data register returns for that pin: the latch when the bit is 1, the synchronized pin level when it is 0. The synchronized pin levels also go to the timer for capture.

The bus has a one-cycle write strobe and combinational read data. Only the two low bits of each register exist. The latch has no reset, so a value written before a reset is still there after it.

Top module: `gpio_tmr_port`

## Requirements
- R1: In both registers only bits 1:0 exist. Bits 7:2 of read data are always 0, and writing them has no effect.
- R2: The latch is at address 0x03 and the direction register is at address 0x07. Any other address reads 0x00, and a write to it changes neither register.
- R3: For a pin not owned by a timer, direction bit 1 gives padOe=1 with padOut equal to the latch bit, and direction bit 0 gives padOe=0.
- R4: Reset clears both direction bits, so padOe is 0 and address 0x07 reads 0x00.
- R5: Reset leaves the latch unchanged. After reset, setting a direction bit drives the value written before the reset.
- R6: Reading 0x03 gives, for bit i, the latch bit when direction bit i is 1 and the synchronized pin level when it is 0. A pad change appears in the read data after two rising clock edges.
- R7: When a channel's 2-bit field in tmrSel (bits 2i+1:2i for pin i) is non-zero, padOe[i]=tmrOe[i] and padOut[i]=tmrOut[i], whatever the direction bit.
- R8: While a timer owns a pin, the read of 0x03 still follows the rule in R6 for that pin's direction bit.
- R9: A latch write takes effect while the pin is an input. In the first cycle that a direction bit reads 1, padOe is 1 and padOut already carries the latch value.
- R10: tmrIn carries the synchronized pin levels, with the same two-edge delay as the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | One-cycle write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| padIn | input | 2 | Raw pad input levels |
| padOe | output | 2 | Pad driver enable per pin |
| padOut | output | 2 | Pad output value per pin |
| tmrSel | input | 4 | Timer mode-select field per channel, 2 bits each |
| tmrOe | input | 2 | Timer output enable per channel |
| tmrOut | input | 2 | Timer output value per channel |
| tmrIn | output | 2 | Synchronized pin levels for the timer |

## Verification
The assertions assume that busWrData is a known value whenever busWrEn is high. They also assume that nothing is written during the reset cycle, since a write there would land on the cleared direction bits. The stimulus raises busWrEn only between falling edges and only with defined data. It keeps reset and writes apart. The latch-hold behaviour is not asserted, because the latch holds an unknown value until its first write. The bench therefore checks it at the ports across a reset.

// File: rtl/gpio_tmr_pkg.sv
package gpio_tmr_pkg;
  // decoded strobes passed from the control to the datapath
  typedef struct packed {
    logic wrLatch;   // write the output latch
    logic wrDir;     // write the direction register
    logic selLatch;  // address hits the latch
    logic selDir;    // address hits the direction register
  } portStrobe_t;
endpackage

// File: rtl/gpio_tmr_ctrl.sv
module gpio_tmr_ctrl
  import gpio_tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h07
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output portStrobe_t       strb
);
  logic hitLatch;
  logic hitDir;

  assign hitLatch = (busAddr == LATCH_ADDR);
  assign hitDir   = (busAddr == DIR_ADDR);

  always_comb begin
    strb          = '0;
    strb.selLatch = hitLatch;
    strb.selDir   = hitDir;
    strb.wrLatch  = busWrEn && hitLatch;
    strb.wrDir    = busWrEn && hitDir;
  end
endmodule

// File: rtl/gpio_tmr_sync.sv
module gpio_tmr_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_tmr_dp.sv
module gpio_tmr_dp
  import gpio_tmr_pkg::*;
#(
  parameter int PINS = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  portStrobe_t           strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [PINS-1:0]       padIn,
  input  logic [PINS*SEL_W-1:0] tmrSel,
  input  logic [PINS-1:0]       tmrOe,
  input  logic [PINS-1:0]       tmrOut,
  output logic [PINS-1:0]       padOe,
  output logic [PINS-1:0]       padOut,
  output logic [PINS-1:0]       tmrIn,
  output logic [DATA_W-1:0]     rdData
);
  localparam int PAD_W = DATA_W - PINS;

  logic [PINS-1:0] latchQ;
  logic [PINS-1:0] dirQ;
  logic [PINS-1:0] pinSync;
  logic [PINS-1:0] tmrOwn;
  logic [PINS-1:0] portView;

  // latch has no reset: keeps its value across reset
  always_ff @(posedge clk) begin
    if (strb.wrLatch) latchQ <= wrData[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirQ <= '0;
    else if (strb.wrDir) dirQ <= wrData[PINS-1:0];
  end

  gpio_tmr_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(padIn),
    .syncOut(pinSync)
  );

  for (genvar i = 0; i < PINS; i++) begin : gPin
    assign tmrOwn[i]   = |tmrSel[i*SEL_W +: SEL_W];
    assign padOe[i]    = tmrOwn[i] ? tmrOe[i]  : dirQ[i];
    assign padOut[i]   = tmrOwn[i] ? tmrOut[i] : latchQ[i];
    assign portView[i] = dirQ[i] ? latchQ[i] : pinSync[i];
  end

  assign tmrIn = pinSync;

  always_comb begin
    if (strb.selLatch)    rdData = {{PAD_W{1'b0}}, portView};
    else if (strb.selDir) rdData = {{PAD_W{1'b0}}, dirQ};
    else                  rdData = '0;
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> dirQ == $past(wrData[PINS-1:0])); // R2
  AST_DIR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirQ)); // R1
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLatch |=> latchQ == $past(wrData[PINS-1:0])); // R9
  AST_DIR_DRIVES_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrDir && !(|tmrSel)) |=> ((padOe == dirQ) && ((padOut & dirQ) == (latchQ & dirQ)))); // R3
endmodule

// File: rtl/gpio_tmr_port.sv
module gpio_tmr_port
  import gpio_tmr_pkg::*;
#(
  parameter int PINS = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h07
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [PINS-1:0]       padIn,
  output logic [PINS-1:0]       padOe,
  output logic [PINS-1:0]       padOut,
  input  logic [PINS*SEL_W-1:0] tmrSel,
  input  logic [PINS-1:0]       tmrOe,
  input  logic [PINS-1:0]       tmrOut,
  output logic [PINS-1:0]       tmrIn
);
  portStrobe_t strb;

  gpio_tmr_ctrl #(.ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR), .DIR_ADDR(DIR_ADDR)) uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strb   (strb)
  );

  gpio_tmr_dp #(.PINS(PINS), .DATA_W(DATA_W), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .padIn  (padIn),
    .tmrSel (tmrSel),
    .tmrOe  (tmrOe),
    .tmrOut (tmrOut),
    .padOe  (padOe),
    .padOut (padOut),
    .tmrIn  (tmrIn),
    .rdData (busRdData)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:PINS] == '0); // R1
endmodule

// File: tb/sim_gpio_tmr_port.sv
module sim_gpio_tmr_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [1:0] padIn = 2'b00;
  logic [1:0] padOe, padOut, tmrIn;
  logic [3:0] tmrSel = 4'h0;
  logic [1:0] tmrOe = 2'b00;
  logic [1:0] tmrOut = 2'b00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_tmr_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .tmrSel(tmrSel), .tmrOe(tmrOe),
    .tmrOut(tmrOut), .tmrIn(tmrIn)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic       wr;
    logic [7:0] wd;
    logic [1:0] pad;
    logic [3:0] sel;
    logic [1:0] tOe;
    logic [1:0] tOut;
    logic [7:0] expRd;
    logic [1:0] expOe;
    logic [1:0] expOut;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 1'b1, 8'hFF, 2'b10, 4'h0, 2'b00, 2'b00, 8'h02, 2'b00, 2'b11, 4'd9}, // R9 R1 preload as input
    '{8'h07, 1'b1, 8'h01, 2'b10, 4'h0, 2'b00, 2'b00, 8'h01, 2'b01, 2'b11, 4'd3}, // R3 R2
    '{8'h03, 1'b0, 8'h00, 2'b00, 4'h0, 2'b00, 2'b00, 8'h01, 2'b01, 2'b11, 4'd6}, // R6 mixed
    '{8'h03, 1'b1, 8'h02, 2'b01, 4'h0, 2'b00, 2'b00, 8'h00, 2'b01, 2'b10, 4'd6}, // R6
    '{8'h07, 1'b1, 8'hFE, 2'b01, 4'h0, 2'b00, 2'b00, 8'h02, 2'b10, 2'b10, 4'd1}, // R1
    '{8'h03, 1'b0, 8'h00, 2'b01, 4'h0, 2'b00, 2'b00, 8'h03, 2'b10, 2'b10, 4'd6}, // R6
    '{8'h03, 1'b0, 8'h00, 2'b00, 4'h4, 2'b00, 2'b10, 8'h02, 2'b00, 2'b10, 4'd7}, // R7 R8
    '{8'h03, 1'b0, 8'h00, 2'b11, 4'h9, 2'b11, 2'b01, 8'h03, 2'b11, 2'b01, 4'd8}, // R8 R7
    '{8'h05, 1'b1, 8'h03, 2'b11, 4'h0, 2'b00, 2'b00, 8'h00, 2'b10, 2'b10, 4'd2}, // R2 stray address
    '{8'h07, 1'b0, 8'h00, 2'b11, 4'h0, 2'b00, 2'b00, 8'h02, 2'b10, 2'b10, 4'd2}  // R2
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    busAddr = 8'h07;
    #1;
    chk("R4 dir reads 0", busRdData, 8'h00);
    chk("R4 padOe off", {6'b0, padOe}, 8'h00);

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      busAddr = VECS[k].addr; busWrEn = VECS[k].wr; busWrData = VECS[k].wd;
      padIn = VECS[k].pad; tmrSel = VECS[k].sel; tmrOe = VECS[k].tOe; tmrOut = VECS[k].tOut;
      @(negedge clk);
      busWrEn = 1'b0;
      repeat (2) @(negedge clk);
      chk($sformatf("R%0d vec%0d rd", VECS[k].req, k), busRdData, VECS[k].expRd);
      chk($sformatf("R%0d vec%0d oe", VECS[k].req, k), {6'b0, padOe}, {6'b0, VECS[k].expOe});
      chk($sformatf("R%0d vec%0d out", VECS[k].req, k), {6'b0, padOut}, {6'b0, VECS[k].expOut});
    end

    // R9 driver turns on showing the latch in the same cycle
    tmrSel = 4'h0;
    busWrite(8'h07, 8'h00);
    busWrite(8'h03, 8'h01);
    @(negedge clk);
    busAddr = 8'h07; busWrData = 8'h01; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    chk("R9 oe at enable", {7'b0, padOe[0]}, 8'h01);
    chk("R9 out at enable", {7'b0, padOut[0]}, 8'h01);
    @(negedge clk);
    busWrEn = 1'b0;

    // R5 latch survives reset, direction cleared
    busWrite(8'h03, 8'h02);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busAddr = 8'h07;
    #1;
    chk("R4 dir cleared", busRdData, 8'h00);
    busWrite(8'h07, 8'h03);
    #1;
    chk("R5 latch kept", {6'b0, padOut}, 8'h02);
    busAddr = 8'h03;
    #1;
    chk("R5 latch read", busRdData, 8'h02);

    // R10 and R6 two-edge latency
    busWrite(8'h07, 8'h00);
    padIn = 2'b00;
    repeat (3) @(negedge clk);
    busAddr = 8'h03;
    padIn = 2'b01;
    @(posedge clk); #1;
    chk("R10 tmrIn after one edge", {6'b0, tmrIn}, 8'h00);
    chk("R6 read after one edge", busRdData, 8'h00);
    @(posedge clk); #1;
    chk("R10 tmrIn after two edges", {6'b0, tmrIn}, 8'h01);
    chk("R6 read after two edges", busRdData, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule